// File: doc/BRIEF.md
# Root Hub Downstream Port Status Controller

This block holds the state of a single downstream port of a USB root hub and shows it to software as one 32-bit word. The low half reports whether a device is attached, whether the port is enabled, suspended, in reset, powered, over current and whether the attached device is low speed. The upper half holds latched change flags that hardware sets on port events and software acknowledges. When software writes the same word, the bits act as one-shot commands rather than as stored values. Software can power the port, enable or disable it, suspend it and start a timed port reset.

Line-state information comes in on plain inputs that are already synchronized to `clk`: device presence, low-speed indication, an overcurrent flag, a pulse marking the end of a full resume sequence and a pulse reporting a port error. The port reset lasts `RESET_TICKS` clock cycles. The default corresponds to 10 ms at 125 MHz, and a bench may pass a short value instead. A single output, `rhsc`, is high whenever any change flag is set, and it feeds the hub's status-change interrupt.

Top module: `rh_port_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0 and `rhsc` is 0.
- R2: Bit 0 (connected) is 1 exactly when `dev_present` is high and the port is powered, and it updates on the clock edge that samples the input. Every change of bit 0 sets change flag bit 16.
- R3: Bit 9 (low-speed device) follows `dev_ls` while bit 0 is 1, and it reads 0 while no device is connected.
- R4: Writing 1 to bit 4 while a device is connected starts a reset, and bit 4 reads 1 for exactly `RESET_TICKS` cycles. When bit 4 drops, change flag bit 20 is set, and bit 1 is set if the device is still connected. A reset request with no device connected is ignored.
- R5: Writing 1 to bit 1 enables the port only when a device is connected. Writing 1 to bit 0 disables the port without setting change flag bit 17.
- R6: When a `port_err` pulse or a loss of connection clears an enabled port, bit 1 drops and change flag bit 17 is set.
- R7: Writing 1 to bit 2 suspends an enabled port. A `resume_done` pulse while the port is suspended clears bit 2 and sets change flag bit 18. The port is never suspended while it is disabled.
- R8: Bit 3 mirrors `oc_in`, and every change of `oc_in` sets change flag bit 19.
- R9: Writing 1 to a change flag (bits 16..20) clears it, and writing 0 leaves it unchanged. A hardware event in the same cycle as a clearing write leaves the flag set.
- R10: `rhsc` is 1 exactly when at least one change flag is set.
- R11: Writing 1 to bit 8 powers the port and writing 1 to bit 9 removes power. Bit 8 reads the power state, and an unpowered port never reports a connection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per command |
| wr_data | input | 32 | Command and acknowledge bits for the write |
| dev_present | input | 1 | Line state shows a device attached |
| dev_ls | input | 1 | Attached device is low speed |
| oc_in | input | 1 | Overcurrent reported for this port |
| resume_done | input | 1 | Pulse: full resume sequence finished |
| port_err | input | 1 | Pulse: hardware error that disables the port |
| rd_data | output | 32 | Port status and change flags |
| rhsc | output | 1 | High while any change flag is set |

## Verification
The bench counts the reset window cycle by cycle. A timer that is off by one leaves bit 4 visible for one cycle too many or too few before the completion flag appears. It clears a change flag in the same cycle as a new overcurrent event, where a design that gives the clear priority loses the event. It disables the port once through software and once through hardware, and a design that flags both would raise change flag 17 after the software write. It also requests reset and enable with nothing attached and removes power under an attached device. A design that skips those guards would show a phantom enable or a connection on a dead port.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int REG_W = 32;

  // status bit positions (software decodes these)
  localparam int B_CONN  = 0;
  localparam int B_ENA   = 1;
  localparam int B_SUSP  = 2;
  localparam int B_OVC   = 3;
  localparam int B_RST   = 4;
  localparam int B_PWR   = 8;
  localparam int B_LOWSP = 9;

  // command bit positions on write
  localparam int C_DISABLE = 0;
  localparam int C_ENABLE  = 1;
  localparam int C_SUSPEND = 2;
  localparam int C_RESET   = 4;
  localparam int C_PWR_ON  = 8;
  localparam int C_PWR_OFF = 9;

  // change flags
  localparam int NUM_CHG  = 5;
  localparam int CHG_BASE = 16;
  localparam int E_CONN = 0;
  localparam int E_ENA  = 1;
  localparam int E_SUSP = 2;
  localparam int E_OVC  = 3;
  localparam int E_RST  = 4;

  typedef struct packed {
    logic disable_p;
    logic enable_p;
    logic suspend_p;
    logic reset_p;
    logic pwr_on;
    logic pwr_off;
  } port_cmd_t;
endpackage

// File: rtl/rhp_reset_timer.sv
module rhp_reset_timer #(
  parameter int RESET_TICKS = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CNT_W = (RESET_TICKS < 2) ? 1 : $clog2(RESET_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESET_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  assign active = act_q;
  assign done   = act_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= LOAD_VAL;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rhp_status_core.sv
module rhp_status_core
  import rhp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  port_cmd_t           cmd,
  input  logic                dev_present,
  input  logic                dev_ls,
  input  logic                oc_in,
  input  logic                resume_done,
  input  logic                port_err,
  input  logic                rst_active,
  input  logic                rst_done,
  output logic                start_reset,
  output logic                conn,
  output logic                ena,
  output logic                susp,
  output logic                ovc,
  output logic                pwr,
  output logic                lowsp,
  output logic [NUM_CHG-1:0]  events
);
  logic conn_n, ena_n, susp_n, ovc_n, pwr_n, lowsp_n;
  logic hw_drop;

  always_comb begin
    pwr_n = pwr;
    if (cmd.pwr_on)  pwr_n = 1'b1;
    if (cmd.pwr_off) pwr_n = 1'b0;

    conn_n  = dev_present && pwr_n;
    lowsp_n = conn_n && dev_ls;
    ovc_n   = oc_in;

    start_reset = cmd.reset_p && conn && !rst_active;

    ena_n = ena;
    if (cmd.enable_p && conn) ena_n = 1'b1;
    if (cmd.disable_p)        ena_n = 1'b0;
    if (rst_done)             ena_n = 1'b1;
    hw_drop = !conn_n || port_err;
    if (hw_drop)              ena_n = 1'b0;

    susp_n = susp;
    if (cmd.suspend_p && ena) susp_n = 1'b1;
    if (resume_done && susp)  susp_n = 1'b0;
    if (start_reset || !ena_n) susp_n = 1'b0;

    events          = '0;
    events[E_CONN]  = conn_n != conn;
    events[E_ENA]   = ena && hw_drop;
    events[E_SUSP]  = resume_done && susp;
    events[E_OVC]   = ovc_n != ovc;
    events[E_RST]   = rst_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conn  <= 1'b0;
      ena   <= 1'b0;
      susp  <= 1'b0;
      ovc   <= 1'b0;
      pwr   <= 1'b0;
      lowsp <= 1'b0;
    end else begin
      conn  <= conn_n;
      ena   <= ena_n;
      susp  <= susp_n;
      ovc   <= ovc_n;
      pwr   <= pwr_n;
      lowsp <= lowsp_n;
    end
  end
endmodule

// File: rtl/rhp_change_flags.sv
module rhp_change_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         any_set
);
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // hardware event outranks a software acknowledge
    assign nxt[i] = set_ev[i] | (flags[i] & ~clr[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      any_set <= 1'b0;
    end else begin
      flags   <= nxt;
      any_set <= |nxt;
    end
  end
endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rhp_pkg::*;
#(
  parameter int RESET_TICKS = 1250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             dev_present,
  input  logic             dev_ls,
  input  logic             oc_in,
  input  logic             resume_done,
  input  logic             port_err,
  output logic [REG_W-1:0] rd_data,
  output logic             rhsc
);
  port_cmd_t          cmd;
  logic               start_reset, rst_active, rst_done;
  logic               conn, ena, susp, ovc, pwr, lowsp;
  logic [NUM_CHG-1:0] events, flags, clr_vec;
  logic               unused_wr_bits;

  always_comb begin
    cmd.disable_p = wr_en && wr_data[C_DISABLE];
    cmd.enable_p  = wr_en && wr_data[C_ENABLE];
    cmd.suspend_p = wr_en && wr_data[C_SUSPEND];
    cmd.reset_p   = wr_en && wr_data[C_RESET];
    cmd.pwr_on    = wr_en && wr_data[C_PWR_ON];
    cmd.pwr_off   = wr_en && wr_data[C_PWR_OFF];
    clr_vec       = wr_en ? wr_data[CHG_BASE +: NUM_CHG] : '0;
  end

  assign unused_wr_bits = ^{wr_data[REG_W-1:CHG_BASE+NUM_CHG], wr_data[CHG_BASE-1:10],
                            wr_data[7:5], wr_data[3]};

  rhp_reset_timer #(.RESET_TICKS(RESET_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start_reset),
    .active (rst_active),
    .done   (rst_done)
  );

  rhp_status_core u_core (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .dev_present (dev_present),
    .dev_ls      (dev_ls),
    .oc_in       (oc_in),
    .resume_done (resume_done),
    .port_err    (port_err),
    .rst_active  (rst_active),
    .rst_done    (rst_done),
    .start_reset (start_reset),
    .conn        (conn),
    .ena         (ena),
    .susp        (susp),
    .ovc         (ovc),
    .pwr         (pwr),
    .lowsp       (lowsp),
    .events      (events)
  );

  rhp_change_flags #(.N(NUM_CHG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (events),
    .clr     (clr_vec),
    .flags   (flags),
    .any_set (rhsc)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[B_CONN]              = conn;
    rd_data[B_ENA]               = ena;
    rd_data[B_SUSP]              = susp;
    rd_data[B_OVC]               = ovc;
    rd_data[B_RST]               = rst_active;
    rd_data[B_PWR]               = pwr;
    rd_data[B_LOWSP]             = lowsp;
    rd_data[CHG_BASE +: NUM_CHG] = flags;
  end
endmodule

// File: rtl/rh_port_ctrl_chk.sv
module rh_port_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] rd_data,
  input logic        rhsc
);
  // R10
  rhsc_tracks_flags_chk: assert property (@(posedge clk) disable iff (rst)
    rhsc == (|rd_data[20:16]));

  // R5
  enable_needs_conn_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |-> rd_data[0]);

  // R7
  suspend_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[2] |-> rd_data[1]);

  // R11
  unpowered_no_conn_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[8] |-> !rd_data[0]);

  // R3
  lowspeed_needs_conn_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[9] |-> rd_data[0]);

  // R4
  reset_start_conn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[4]) |-> $past(rd_data[0]));

  // R4
  reset_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_data[4]) |-> rd_data[20]);
endmodule

bind rh_port_ctrl rh_port_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_data (rd_data),
  .rhsc    (rhsc)
);

// File: tb/rh_port_ctrl_test.sv
module rh_port_ctrl_test;
  localparam int TICKS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dev_present = 1'b0, dev_ls = 1'b0, oc_in = 1'b0;
  logic        resume_done = 1'b0, port_err = 1'b0;
  logic [31:0] rd_data;
  logic        rhsc;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   applied = 0;
  int   miscompares = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  rh_port_ctrl #(.RESET_TICKS(TICKS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dev_present(dev_present), .dev_ls(dev_ls), .oc_in(oc_in),
    .resume_done(resume_done), .port_err(port_err),
    .rd_data(rd_data), .rhsc(rhsc)
  );

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic erh;
      e = q.pop_front();
      erh = |e.val[20:16];
      applied++;
      if (rd_data !== e.val || rhsc !== erh) begin
        miscompares++;
        $display("FAIL %s: rd_data=%h expected %h, rhsc=%b expected %b",
                 e.tag, rd_data, e.val, rhsc, erh);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_val(input logic [31:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic write_cmd(input logic [31:0] d, input logic [31:0] v, input string tag);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
    wr_data = '0;
    expect_val(v, tag);
  endtask

  task automatic step(input logic [31:0] v, input string tag);
    tick();
    expect_val(v, tag);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    step(32'h0000_0000, "R1 reset state");
    dev_present = 1'b1;
    step(32'h0000_0000, "R11 no connect while unpowered");
    write_cmd(32'h0000_0100, 32'h0001_0101, "R2 R11 power on with device");
    write_cmd(32'h0001_0000, 32'h0000_0101, "R9 R10 clear connect flag");
    write_cmd(32'h0000_0002, 32'h0000_0103, "R5 enable");
    write_cmd(32'h0000_0001, 32'h0000_0101, "R5 software disable no flag");
    write_cmd(32'h0000_0010, 32'h0000_0111, "R4 reset start");
    for (int i = 0; i < TICKS - 1; i++) step(32'h0000_0111, "R4 reset held");
    step(32'h0010_0103, "R4 reset end enables");
    write_cmd(32'h0010_0000, 32'h0000_0103, "R9 clear reset flag");
    dev_ls = 1'b1;
    step(32'h0000_0303, "R3 low speed");
    write_cmd(32'h0000_0004, 32'h0000_0307, "R7 suspend");
    resume_done = 1'b1;
    step(32'h0004_0303, "R7 resume complete");
    resume_done = 1'b0;
    write_cmd(32'h0004_0000, 32'h0000_0303, "R9 clear suspend flag");
    oc_in = 1'b1;
    step(32'h0008_030B, "R8 overcurrent rise");
    oc_in = 1'b0;
    step(32'h0008_0303, "R8 overcurrent fall");
    oc_in = 1'b1;
    write_cmd(32'h0008_0000, 32'h0008_030B, "R9 event beats clear");
    oc_in = 1'b0;
    step(32'h0008_0303, "R8 overcurrent fall again");
    write_cmd(32'h0008_0000, 32'h0000_0303, "R9 clear overcurrent flag");
    port_err = 1'b1;
    step(32'h0002_0301, "R6 port error disables");
    port_err = 1'b0;
    write_cmd(32'h0002_0000, 32'h0000_0301, "R9 clear enable flag");
    write_cmd(32'h0000_0002, 32'h0000_0303, "R5 re-enable");
    dev_present = 1'b0;
    step(32'h0003_0100, "R2 R6 R3 disconnect");
    write_cmd(32'h0000_0000, 32'h0003_0100, "R9 zero write keeps flags");
    write_cmd(32'h0003_0000, 32'h0000_0100, "R9 clear both flags");
    write_cmd(32'h0000_0010, 32'h0000_0100, "R4 reset ignored without device");
    write_cmd(32'h0000_0002, 32'h0000_0100, "R5 enable ignored without device");
    dev_ls = 1'b0;
    dev_present = 1'b1;
    step(32'h0001_0101, "R2 reconnect");
    write_cmd(32'h0000_0200, 32'h0001_0000, "R11 power off drops connect");
    write_cmd(32'h0001_0000, 32'h0000_0000, "R10 all flags clear");
    step(32'h0000_0000, "R11 stays unpowered");
    tick();
    finished = 1'b1;
    report();
  end
endmodule